// File: doc/BRIEF.md
# Maskable Interrupt Gate and Restart Mask Controller

This block is the interrupt control unit of a small 8-bit processor core. It holds a global enable flip-flop for maskable interrupts. It also holds three individual mask bits for the vectored restart requests named 7.5, 6.5 and 5.5, an edge-capture latch for the 7.5 request, and a latch that drives a serial output pin. The core's decoder drives four operation strobes: enable, disable, mask-load from the accumulator, and status-read into the accumulator.

At every instruction boundary the core raises a one-cycle pulse. In that same cycle the block reports which pending source the core must service. The non-maskable trap line is not gated by the enable flip-flop or by any mask bit. The enable operation has a one-instruction delay: a maskable request is never taken at the boundary that ends the enable instruction. Vector generation and the acknowledge cycles belong to the core.

Top module: `irq_gate_ctl`

## Requirements
- R1: During reset and after it, the enable flip-flop is 0, all three masks are 1, the 7.5 capture latch is 0, `ser_out` is 0, `acc_out` is 0x00, and no maskable request is taken.
- R2: `take_src` is combinational and valid only while `boundary` is 1. Its codes are 0 = none, 1 = trap, 2 = restart 7.5, 3 = restart 6.5, 4 = restart 5.5, 5 = general INTR. It is 0 whenever `boundary` is 0.
- R3: `op_en` sets the enable flip-flop. At the first boundary after the strobe, no maskable source is taken. From the second boundary on, maskable sources may be taken.
- R4: `op_dis` clears the enable flip-flop. Until the next `op_en`, no maskable source is taken.
- R5: The trap line is taken at any boundary, whatever the enable and mask state. Taking it leaves the enable flip-flop unchanged.
- R6: With `op_mask` high, accumulator bit 3 = 1 loads the masks from bits 2:0 (bit 0 = 5.5, bit 1 = 6.5, bit 2 = 7.5, 1 = masked). With bit 3 = 0, the masks are unchanged. The masks never gate INTR or trap.
- R7: `op_mask` with accumulator bit 4 = 1 clears the 7.5 capture latch.
- R8: `op_mask` with accumulator bit 6 = 1 copies bit 7 to `ser_out`. With bit 6 = 0, `ser_out` holds its value.
- R9: One cycle after `op_read`, `acc_out` holds the status word. Bits 2:0 are the masks, bit 3 is the enable flip-flop, bit 4 is the 5.5 line, bit 5 is the 6.5 line, bit 6 is the 7.5 capture latch and bit 7 is `ser_in`. Between reads, `acc_out` holds its value.
- R10: A rising edge on `irq_r75` sets the capture latch, even while 7.5 is masked. The latch stays set after the line falls and clears when 7.5 is taken. Requests 6.5 and 5.5 are level sensitive: they are only taken while their line is high.
- R11: Taking any maskable source clears the enable flip-flop.
- R12: When several sources are eligible together, the priority is trap, then 7.5, then 6.5, then 5.5, then INTR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_en | input | 1 | Enable-interrupts operation strobe |
| op_dis | input | 1 | Disable-interrupts operation strobe |
| op_mask | input | 1 | Load-mask operation strobe |
| op_read | input | 1 | Read-status operation strobe |
| acc_in | input | 8 | Accumulator value for mask load |
| boundary | input | 1 | One-cycle instruction boundary pulse |
| irq_intr | input | 1 | General maskable request (level) |
| irq_r75 | input | 1 | Restart 7.5 request (edge) |
| irq_r65 | input | 1 | Restart 6.5 request (level) |
| irq_r55 | input | 1 | Restart 5.5 request (level) |
| irq_trap | input | 1 | Non-maskable trap request (level) |
| ser_in | input | 1 | Serial input pin |
| ser_out | output | 1 | Serial output pin latch |
| acc_out | output | 8 | Status word for the accumulator |
| take_src | output | 3 | Source to service at this boundary |

## Verification
The assertions assume four things about the inputs. At most one operation strobe is high in any cycle. `boundary` is a single-cycle pulse. The operation strobe of an instruction comes in an earlier cycle than the boundary that ends it. The 7.5 line is low when reset is released. The stimulus raises each strobe for exactly one cycle between boundaries, lowers every request line around each reset, and changes inputs only at the falling edge. As a result, the one-instruction delay after enable and the set-wins rule of the 7.5 latch are always exercised in the ordering the core produces.

// File: rtl/irq_gate_pkg.sv
// Shared constants for the interrupt gate: source codes, control-word
// and status-word bit positions. Assumes an 8-bit accumulator.
package irq_gate_pkg;
    localparam int ACC_W  = 8;
    localparam int NMASK  = 3;
    localparam int NSRC   = 5;
    localparam int SRC_W  = $clog2(NSRC + 1);

    // source codes reported at a boundary
    localparam logic [SRC_W-1:0] SRC_NONE = 3'd0;
    localparam logic [SRC_W-1:0] SRC_TRAP = 3'd1;
    localparam logic [SRC_W-1:0] SRC_R75  = 3'd2;
    localparam logic [SRC_W-1:0] SRC_R65  = 3'd3;
    localparam logic [SRC_W-1:0] SRC_R55  = 3'd4;
    localparam logic [SRC_W-1:0] SRC_INTR = 3'd5;

    // request vector slots, index 0 is highest priority
    localparam int SLOT_TRAP = 0;
    localparam int SLOT_R75  = 1;
    localparam int SLOT_R65  = 2;
    localparam int SLOT_R55  = 3;
    localparam int SLOT_INTR = 4;

    // mask bit positions (in both control and status words)
    localparam int M55_BIT = 0;
    localparam int M65_BIT = 1;
    localparam int M75_BIT = 2;

    // control word fields
    localparam int MLD_BIT  = 3;
    localparam int CLR_BIT  = 4;
    localparam int RSVD_BIT = 5;
    localparam int SOE_BIT  = 6;
    localparam int SOD_BIT  = 7;

    // status word fields
    localparam int ST_IE_BIT  = 3;
    localparam int ST_P55_BIT = 4;
    localparam int ST_P65_BIT = 5;
    localparam int ST_P75_BIT = 6;
    localparam int ST_SI_BIT  = 7;
endpackage

// File: rtl/irq_gate_enable.sv
// Global maskable-interrupt enable with one-instruction arming delay.
// Assumes op strobes are single-cycle and at most one is high at a time.
// hold_q marks that the boundary ending the enable instruction is still ahead.
module irq_gate_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic en_op,
    input  logic dis_op,
    input  logic boundary,
    input  logic mask_taken,
    output logic ie_q,
    output logic hold_q,
    output logic elig
);
    // update enable flop and arming hold bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            if (dis_op)          ie_q <= 1'b0;
            else if (en_op)      ie_q <= 1'b1;
            else if (mask_taken) ie_q <= 1'b0;

            if (dis_op)          hold_q <= 1'b0;
            else if (en_op)      hold_q <= !boundary;
            else if (boundary)   hold_q <= 1'b0;
        end
    end

    // maskable sources may be taken only when armed and no op in flight
    always_comb elig = ie_q & ~hold_q & ~en_op & ~dis_op;

    // R4
    dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dis_op |=> !ie_q);
    // R3
    en_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_op && !dis_op) |=> (ie_q && (hold_q == !$past(boundary))));
endmodule

// File: rtl/irq_gate_mask.sv
// Restart mask bits, 7.5 edge-capture latch and serial output latch.
// Assumes ctl is the accumulator value, sampled only while set_op is high.
module irq_gate_mask
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_op,
    input  logic [ACC_W-1:0] ctl,
    input  logic             req75,
    input  logic             take75,
    output logic [NMASK-1:0] mask_q,
    output logic             pend75_q,
    output logic             ser_q
);
    logic prev75_q;
    logic rise75;
    logic unused_rsvd;

    assign unused_rsvd = ctl[RSVD_BIT];

    // detect a low-to-high step on the 7.5 line
    always_comb rise75 = req75 & ~prev75_q;

    // register masks, capture latch, serial latch and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '1;
            pend75_q <= 1'b0;
            ser_q    <= 1'b0;
            prev75_q <= 1'b0;
        end else begin
            prev75_q <= req75;
            if (set_op && ctl[MLD_BIT])
                mask_q <= ctl[NMASK-1:0];
            if (rise75)
                pend75_q <= 1'b1;
            else if (take75 || (set_op && ctl[CLR_BIT]))
                pend75_q <= 1'b0;
            if (set_op && ctl[SOE_BIT])
                ser_q <= ctl[SOD_BIT];
        end
    end

    // R6
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_op && ctl[MLD_BIT]) |=> (mask_q == $past(ctl[NMASK-1:0])));
    // R8
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_op && ctl[SOE_BIT]) |=> $stable(ser_q));
    // R10
    r75_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req75) |=> pend75_q);
endmodule

// File: rtl/irq_gate_arb.sv
// Fixed-priority picker: lowest set index wins, reported as index + 1.
// Assumes the caller has already gated every request by the boundary pulse.
module irq_gate_arb #(
    parameter int NREQ = 5,
    parameter int OUT_W = $clog2(NREQ + 1)
) (
    input  logic [NREQ-1:0]  req,
    output logic [OUT_W-1:0] win
);
    // scan from lowest priority up so the highest set request is kept
    always_comb begin
        win = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) win = OUT_W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_gate_ctl.sv
// Interrupt control unit top: enable gate, mask bank, priority picker and
// status readback. Assumes boundary is a one-cycle pulse from the core and
// the op strobe of an instruction precedes its boundary.
module irq_gate_ctl
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_en,
    input  logic             op_dis,
    input  logic             op_mask,
    input  logic             op_read,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             boundary,
    input  logic             irq_intr,
    input  logic             irq_r75,
    input  logic             irq_r65,
    input  logic             irq_r55,
    input  logic             irq_trap,
    input  logic             ser_in,
    output logic             ser_out,
    output logic [ACC_W-1:0] acc_out,
    output logic [SRC_W-1:0] take_src
);
    logic             ie_q, hold_q, elig;
    logic [NMASK-1:0] mask_q;
    logic             pend75_q;
    logic [NSRC-1:0]  req_v;
    logic             mask_taken, take75;
    logic [ACC_W-1:0] status_w;

    irq_gate_enable u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_op      (op_en),
        .dis_op     (op_dis),
        .boundary   (boundary),
        .mask_taken (mask_taken),
        .ie_q       (ie_q),
        .hold_q     (hold_q),
        .elig       (elig)
    );

    irq_gate_mask u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_op   (op_mask),
        .ctl      (acc_in),
        .req75    (irq_r75),
        .take75   (take75),
        .mask_q   (mask_q),
        .pend75_q (pend75_q),
        .ser_q    (ser_out)
    );

    // build the boundary-gated request vector in priority order
    always_comb begin
        req_v            = '0;
        req_v[SLOT_TRAP] = boundary & irq_trap;
        req_v[SLOT_R75]  = boundary & elig & pend75_q & ~mask_q[M75_BIT];
        req_v[SLOT_R65]  = boundary & elig & irq_r65  & ~mask_q[M65_BIT];
        req_v[SLOT_R55]  = boundary & elig & irq_r55  & ~mask_q[M55_BIT];
        req_v[SLOT_INTR] = boundary & elig & irq_intr;
    end

    irq_gate_arb #(.NREQ(NSRC), .OUT_W(SRC_W)) u_arb (
        .req (req_v),
        .win (take_src)
    );

    // decode acceptance side effects
    always_comb begin
        mask_taken = (take_src >= SRC_R75) && (take_src <= SRC_INTR);
        take75     = (take_src == SRC_R75);
    end

    // assemble the status word
    always_comb begin
        status_w                = '0;
        status_w[NMASK-1:0]     = mask_q;
        status_w[ST_IE_BIT]     = ie_q;
        status_w[ST_P55_BIT]    = irq_r55;
        status_w[ST_P65_BIT]    = irq_r65;
        status_w[ST_P75_BIT]    = pend75_q;
        status_w[ST_SI_BIT]     = ser_in;
    end

    // capture the status word on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_out <= '0;
        else if (op_read) acc_out <= status_w;
    end

    // R5
    trap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && irq_trap) |-> (take_src == SRC_TRAP));
    // R3
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && hold_q) |-> (take_src == SRC_NONE || take_src == SRC_TRAP));
    // R11
    taken_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_src >= SRC_R75 && take_src <= SRC_INTR) |=> !ie_q);
    // R9
    read_si_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_read |=> (acc_out[ST_SI_BIT] == $past(ser_in)));
    // R2
    idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |-> (take_src == SRC_NONE));
endmodule

// File: tb/irq_gate_ctl_tb.sv
module irq_gate_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 0, op_dis = 0, op_mask = 0, op_read = 0;
    logic [7:0] acc_in = 8'h00;
    logic       boundary = 0;
    logic       irq_intr = 0, irq_r75 = 0, irq_r65 = 0, irq_r55 = 0, irq_trap = 0;
    logic       ser_in = 0;
    logic       ser_out;
    logic [7:0] acc_out;
    logic [2:0] take_src;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_gate_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_dis(op_dis),
        .op_mask(op_mask), .op_read(op_read), .acc_in(acc_in),
        .boundary(boundary), .irq_intr(irq_intr), .irq_r75(irq_r75),
        .irq_r65(irq_r65), .irq_r55(irq_r55), .irq_trap(irq_trap),
        .ser_in(ser_in), .ser_out(ser_out), .acc_out(acc_out),
        .take_src(take_src)
    );

    // {trap, r75, r65, r55, intr}, masks {7.5,6.5,5.5}, expected source
    localparam logic [10:0] VEC [10] = '{
        {5'b10001, 3'b000, 3'd1},
        {5'b01111, 3'b000, 3'd2},
        {5'b00111, 3'b000, 3'd3},
        {5'b00011, 3'b000, 3'd4},
        {5'b00001, 3'b000, 3'd5},
        {5'b01111, 3'b100, 3'd3},
        {5'b01110, 3'b111, 3'd0},
        {5'b01111, 3'b111, 3'd5},
        {5'b11111, 3'b111, 3'd1},
        {5'b00101, 3'b010, 3'd5}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        {irq_intr, irq_r75, irq_r65, irq_r55, irq_trap, ser_in} = '0;
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic pulse_en();  op_en = 1;  step(); op_en = 0;  endtask
    task automatic pulse_dis(); op_dis = 1; step(); op_dis = 0; endtask

    task automatic set_mask(input logic [7:0] w);
        acc_in = w; op_mask = 1; step(); op_mask = 0; acc_in = 8'h00;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] exp);
        op_read = 1; step(); op_read = 0;
        check(tag, acc_out, exp);
    endtask

    task automatic bnd_chk(input string tag, input logic [2:0] exp);
        boundary = 1; #1;
        check(tag, {5'd0, take_src}, {5'd0, exp});
        step(); boundary = 0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        do_reset();
        // R1 reset state
        check("R1 acc_out after reset", acc_out, 8'h00);
        check("R1 ser_out after reset", {7'd0, ser_out}, 8'h00);
        irq_intr = 1; irq_r65 = 1; irq_r55 = 1;
        bnd_chk("R1 nothing taken after reset", 3'd0);
        irq_intr = 0; irq_r65 = 0; irq_r55 = 0;
        read_chk("R1 status after reset", 8'h07);
        // R2 no report without boundary
        irq_trap = 1; #1;
        check("R2 idle take_src", {5'd0, take_src}, 8'h00);
        step(); irq_trap = 0;

        // R12 priority table
        for (int k = 0; k < 10; k++) begin
            do_reset();
            set_mask(8'h18 | {5'd0, VEC[k][5:3]});
            pulse_en();
            bnd_chk("R3 arm boundary", 3'd0);
            {irq_trap, irq_r75, irq_r65, irq_r55, irq_intr} = VEC[k][10:6];
            step();
            bnd_chk($sformatf("R12 vector %0d", k), VEC[k][2:0]);
            {irq_trap, irq_r75, irq_r65, irq_r55, irq_intr} = '0;
        end

        // R3 enable delay, R11 clear on take
        do_reset();
        set_mask(8'h08);
        irq_intr = 1;
        pulse_en();
        bnd_chk("R3 first boundary blocked", 3'd0);
        bnd_chk("R3 second boundary taken", 3'd5);
        irq_intr = 0;
        read_chk("R11 enable cleared by take", 8'h00);

        // R4 disable
        do_reset();
        pulse_en();
        bnd_chk("R4 arm", 3'd0);
        pulse_dis();
        irq_intr = 1;
        bnd_chk("R4 blocked after disable", 3'd0);
        irq_intr = 0;
        read_chk("R4 status after disable", 8'h07);

        // R5 trap independent of enable state, leaves enable set
        do_reset();
        irq_trap = 1;
        bnd_chk("R5 trap with enable off", 3'd1);
        irq_trap = 0;
        pulse_en();
        bnd_chk("R5 arm", 3'd0);
        irq_trap = 1;
        bnd_chk("R5 trap with enable on", 3'd1);
        irq_trap = 0;
        read_chk("R5 enable kept after trap", 8'h0F);

        // R6 mask load gating
        do_reset();
        set_mask(8'h00);
        read_chk("R6 masks kept when load bit clear", 8'h07);
        set_mask(8'h0A);
        read_chk("R6 masks loaded", 8'h02);

        // R7 capture latch clear by control word; R10 captured while masked
        do_reset();
        irq_r75 = 1; step(); irq_r75 = 0; step();
        read_chk("R10 latch set while masked", 8'h47);
        set_mask(8'h10);
        read_chk("R7 latch cleared", 8'h07);

        // R8 serial output
        set_mask(8'hC0);
        check("R8 ser_out set", {7'd0, ser_out}, 8'h01);
        set_mask(8'h00);
        check("R8 ser_out held", {7'd0, ser_out}, 8'h01);
        set_mask(8'h40);
        check("R8 ser_out cleared", {7'd0, ser_out}, 8'h00);

        // R9 serial input in status bit 7, value held between reads
        do_reset();
        ser_in = 1;
        read_chk("R9 serial in bit", 8'h87);
        ser_in = 0; step();
        check("R9 status held", acc_out, 8'h87);

        // R10 level vs edge behaviour
        do_reset();
        set_mask(8'h08);
        pulse_en();
        bnd_chk("R10 arm", 3'd0);
        irq_r65 = 1;
        read_chk("R10 6.5 level shown", 8'h28);
        irq_r65 = 0;
        bnd_chk("R10 6.5 gone when low", 3'd0);
        irq_r75 = 1; step(); irq_r75 = 0; step();
        read_chk("R10 7.5 latched", 8'h48);
        bnd_chk("R10 7.5 taken after fall", 3'd2);
        read_chk("R10 latch cleared on take", 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule